// File: doc/BRIEF.md
# Edge-Capturing Input Port with Interrupt

This block samples a group of asynchronous input pins, brings them into the clock domain, and records in a sticky per-pin flag every occurrence of a chosen transition. A flag that is also enabled in the interrupt mask drives a level interrupt towards the processor. Software reaches the block through a small word-addressed slave port. Through it, software reads the current pin levels, programs the mask, and inspects or clears the flags.

The transition to watch for is fixed when the block is built: low-to-high, high-to-low, or either. The flag register is also optional at build time. Its clearing rule is a build option too: a write may clear every flag, or it may clear only the bits written as 1. A typical handler reads the flags, services each set bit, and then clears the flags before it returns.

The slave port has no handshake. A read is accepted in the cycle `read` is high, and its data appears on `readdata` one cycle later. A write takes effect at the clock edge where `write` is high.

Top module: `edgecap_inport`

## Requirements
- R1: A transition on pin n is flagged in bit n of the capture register after the third rising clock edge that follows the pin change. The first edge samples the pin, the second edge completes synchronization, and the third edge sets the flag.
- R2: A read at word offset 0 returns the synchronized pin levels. These are the pin values sampled two clock edges before the read is accepted.
- R3: The watched transition is set by the `EDGE_KIND` parameter: 0 = rising only, 1 = falling only, 2 = both.
- R4: A capture flag stays set until software clears it. Further pin activity does not clear it, and neither does time passing.
- R5: With `BITWISE_CLEAR`=1, a write at word offset 3 clears exactly the flags whose `writedata` bit is 1. Flags written with 0 keep their value.
- R6: With `BITWISE_CLEAR`=0, any write at word offset 3 clears every flag, whatever the data.
- R7: If a transition is detected on pin n in the same cycle that a write clears flag n, flag n ends up set.
- R8: Word offset 2 is the interrupt mask. It is read/write, and bit n enables the interrupt for pin n.
- R9: `irq` is high exactly while some flag is set whose mask bit is also set. It is a level output with no extra delay beyond the registers.
- R10: With `CAPTURE_EN`=0, reads at offset 3 return zero, writes there change nothing, and `irq` stays low.
- R11: Reads at word offset 1 return zero. Writes at offsets 0 and 1 change no state.
- R12: A synchronous reset clears the synchronizers, flags, mask and `readdata`, and drives `irq` low.
- R13: `readdata` carries the addressed word in the cycle after a read is accepted. It is zero in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | WIDTH | Asynchronous input pins |
| address | input | ADDR_W | Word offset of the access |
| read | input | 1 | Read strobe |
| write | input | 1 | Write strobe |
| writedata | input | WIDTH | Write data |
| readdata | output | WIDTH | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the very cycle a new transition is detected. Detection trails the pin by two synchronizer stages, so the bench changes a pin and then asserts the clearing write exactly two cycles later. The flag must then still read as set. Four builds run side by side on shared stimulus, covering rising/bitwise, falling/clear-all, both-edge and capture-less variants. Each is compared every cycle against a queue-based reference model, so single-cycle pulses and dense pin patterns are checked in every configuration.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_e;

  localparam int OFF_DATA = 0;
  localparam int OFF_MASK = 2;
  localparam int OFF_CAP  = 3;

endpackage

// File: rtl/edgecap_sync.sv
module edgecap_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/edgecap_detect.sv
module edgecap_detect
  import edgecap_pkg::*;
#(
  parameter int         WIDTH     = 8,
  parameter edge_kind_e EDGE_KIND = EDGE_RISE
) (
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] prev_i,
  output logic [WIDTH-1:0] hit_o
);

  generate
    if (EDGE_KIND == EDGE_RISE) begin : g_rise
      assign hit_o = lvl_i & ~prev_i;
    end else if (EDGE_KIND == EDGE_FALL) begin : g_fall
      assign hit_o = ~lvl_i & prev_i;
    end else begin : g_any
      assign hit_o = lvl_i ^ prev_i;
    end
  endgenerate

endmodule

// File: rtl/edgecap_flags.sv
module edgecap_flags #(
  parameter int WIDTH         = 8,
  parameter bit CAPTURE_EN    = 1'b1,
  parameter bit BITWISE_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] flags_o
);

  generate
    if (CAPTURE_EN) begin : g_cap
      logic [WIDTH-1:0] flags_q;
      logic [WIDTH-1:0] keep;

      // Bits that survive this cycle's clear request.
      if (BITWISE_CLEAR) begin : g_bitwise
        assign keep = clr_i ? ~clr_data_i : '1;
      end else begin : g_all
        assign keep = clr_i ? '0 : '1;
      end

      // A fresh hit is ORed in after the clear, so it always survives.
      always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & keep) | hit_i;
      end

      assign flags_o = flags_q;
    end else begin : g_nocap
      assign flags_o = '0;
    end
  endgenerate

endmodule

// File: rtl/edgecap_inport.sv
module edgecap_inport
  import edgecap_pkg::*;
#(
  parameter int         WIDTH         = 8,
  parameter edge_kind_e EDGE_KIND     = EDGE_RISE,
  parameter bit         CAPTURE_EN    = 1'b1,
  parameter bit         BITWISE_CLEAR = 1'b1,
  parameter int         ADDR_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  pins_i,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [WIDTH-1:0]  writedata,
  output logic [WIDTH-1:0]  readdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFF_CAP);

  logic [WIDTH-1:0] lvl_v;
  logic [WIDTH-1:0] prev_v;
  logic [WIDTH-1:0] hit_v;
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] rd_mux;
  logic             cap_wr;

  edgecap_sync #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pins_i),
    .lvl_o  (lvl_v),
    .prev_o (prev_v)
  );

  edgecap_detect #(.WIDTH(WIDTH), .EDGE_KIND(EDGE_KIND)) u_detect (
    .lvl_i  (lvl_v),
    .prev_i (prev_v),
    .hit_o  (hit_v)
  );

  assign cap_wr = write && (address == A_CAP);

  edgecap_flags #(
    .WIDTH         (WIDTH),
    .CAPTURE_EN    (CAPTURE_EN),
    .BITWISE_CLEAR (BITWISE_CLEAR)
  ) u_flags (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit_v),
    .clr_i      (cap_wr),
    .clr_data_i (writedata),
    .flags_o    (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                              mask_q <= '0;
    else if (write && address == A_MASK) mask_q <= writedata;
  end

  always_comb begin
    rd_mux = '0;
    unique case (address)
      A_DATA:  rd_mux = lvl_v;
      A_MASK:  rd_mux = mask_q;
      A_CAP:   rd_mux = flags_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) readdata <= '0;
    else     readdata <= read ? rd_mux : '0;
  end

  assign irq = |(flags_q & mask_q);

endmodule

// File: rtl/edgecap_inport_chk.sv
module edgecap_inport_chk #(
  parameter int WIDTH         = 8,
  parameter bit CAPTURE_EN    = 1'b1,
  parameter bit BITWISE_CLEAR = 1'b1,
  parameter int ADDR_W        = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] address,
  input logic              read,
  input logic              write,
  input logic [WIDTH-1:0]  writedata,
  input logic [WIDTH-1:0]  readdata,
  input logic              irq,
  input logic [WIDTH-1:0]  flags,
  input logic [WIDTH-1:0]  mask,
  input logic [WIDTH-1:0]  hit
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(3);

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    !(write && address == A_CAP) |=> (($past(flags) & ~flags) == '0));

  a_r5_bit_clear: assert property (@(posedge clk) disable iff (rst)
    (CAPTURE_EN && BITWISE_CLEAR && write && address == A_CAP)
      |=> (flags == (($past(flags) & ~$past(writedata)) | $past(hit))));

  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    (CAPTURE_EN && !BITWISE_CLEAR && write && address == A_CAP)
      |=> (flags == $past(hit)));

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (CAPTURE_EN && hit != '0) |=> ((flags & $past(hit)) == $past(hit)));

  a_r8_mask_write: assert property (@(posedge clk) disable iff (rst)
    (write && address == A_MASK) |=> (mask == $past(writedata)));

  a_r10_no_capture: assert property (@(posedge clk) disable iff (rst)
    (!CAPTURE_EN && read && address == A_CAP) |=> (readdata == '0 && !irq));

  a_r13_idle_read: assert property (@(posedge clk) disable iff (rst)
    !read |=> (readdata == '0));

endmodule

bind edgecap_inport edgecap_inport_chk #(
  .WIDTH         (WIDTH),
  .CAPTURE_EN    (CAPTURE_EN),
  .BITWISE_CLEAR (BITWISE_CLEAR),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .address   (address),
  .read      (read),
  .write     (write),
  .writedata (writedata),
  .readdata  (readdata),
  .irq       (irq),
  .flags     (flags_q),
  .mask      (mask_q),
  .hit       (hit_v)
);

// File: tb/edgecap_inport_tb.sv
module edgecap_ref #(
  parameter int W    = 8,
  parameter int KIND = 0,
  parameter bit CAP  = 1'b1,
  parameter bit BITW = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic [1:0]   addr,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wd,
  output logic [W-1:0] exp_rdata,
  output logic         exp_irq
);
  logic [W-1:0] hist[$];
  logic [W-1:0] flags;
  logic [W-1:0] mask;

  always @(posedge clk) begin
    logic [W-1:0] now, old, seen, nxt;
    if (rst) begin
      hist = {};
      repeat (3) hist.push_front('0);
      flags = '0;
      mask = '0;
      exp_rdata = '0;
    end else begin
      now = hist[1];
      old = hist[2];
      case (KIND)
        0:       seen = now & ~old;
        1:       seen = ~now & old;
        default: seen = now ^ old;
      endcase
      if (!CAP) seen = '0;
      nxt = '0;
      if (rd) begin
        case (addr)
          2'd0:    nxt = now;
          2'd2:    nxt = mask;
          2'd3:    nxt = CAP ? flags : '0;
          default: nxt = '0;
        endcase
      end
      if (wr && addr == 2'd3 && CAP) flags = BITW ? (flags & ~wd) : '0;
      flags = flags | seen;
      if (wr && addr == 2'd2) mask = wd;
      exp_rdata = nxt;
      void'(hist.pop_back());
      hist.push_front(pins);
    end
    exp_irq = |(flags & mask);
  end
endmodule

module edgecap_inport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pins = '0;
  logic [1:0]   addr = '0;
  logic         rd = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [1:0]   last_addr = '0;
  bit           chk_on = 1'b0;
  bit           done = 1'b0;
  int           n_chk = 0;
  int           n_bad = 0;

  logic [W-1:0] rdata [4];
  logic         irqs  [4];
  logic [W-1:0] e_rdata [4];
  logic         e_irq  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance 0: rising, bitwise clear. 1: falling, clear-all.
  // 2: both edges, bitwise. 3: no capture register.
  edgecap_inport #(.WIDTH(W), .EDGE_KIND(edgecap_pkg::EDGE_RISE),
    .CAPTURE_EN(1'b1), .BITWISE_CLEAR(1'b1)) u_dut (
    .clk(clk), .rst(rst), .pins_i(pins), .address(addr), .read(rd), .write(wr),
    .writedata(wd), .readdata(rdata[0]), .irq(irqs[0]));
  edgecap_inport #(.WIDTH(W), .EDGE_KIND(edgecap_pkg::EDGE_FALL),
    .CAPTURE_EN(1'b1), .BITWISE_CLEAR(1'b0)) u_dut_fall (
    .clk(clk), .rst(rst), .pins_i(pins), .address(addr), .read(rd), .write(wr),
    .writedata(wd), .readdata(rdata[1]), .irq(irqs[1]));
  edgecap_inport #(.WIDTH(W), .EDGE_KIND(edgecap_pkg::EDGE_ANY),
    .CAPTURE_EN(1'b1), .BITWISE_CLEAR(1'b1)) u_dut_any (
    .clk(clk), .rst(rst), .pins_i(pins), .address(addr), .read(rd), .write(wr),
    .writedata(wd), .readdata(rdata[2]), .irq(irqs[2]));
  edgecap_inport #(.WIDTH(W), .EDGE_KIND(edgecap_pkg::EDGE_RISE),
    .CAPTURE_EN(1'b0), .BITWISE_CLEAR(1'b1)) u_dut_nocap (
    .clk(clk), .rst(rst), .pins_i(pins), .address(addr), .read(rd), .write(wr),
    .writedata(wd), .readdata(rdata[3]), .irq(irqs[3]));

  edgecap_ref #(.W(W), .KIND(0), .CAP(1'b1), .BITW(1'b1)) m0 (
    .clk(clk), .rst(rst), .pins(pins), .addr(addr), .rd(rd), .wr(wr), .wd(wd),
    .exp_rdata(e_rdata[0]), .exp_irq(e_irq[0]));
  edgecap_ref #(.W(W), .KIND(1), .CAP(1'b1), .BITW(1'b0)) m1 (
    .clk(clk), .rst(rst), .pins(pins), .addr(addr), .rd(rd), .wr(wr), .wd(wd),
    .exp_rdata(e_rdata[1]), .exp_irq(e_irq[1]));
  edgecap_ref #(.W(W), .KIND(2), .CAP(1'b1), .BITW(1'b1)) m2 (
    .clk(clk), .rst(rst), .pins(pins), .addr(addr), .rd(rd), .wr(wr), .wd(wd),
    .exp_rdata(e_rdata[2]), .exp_irq(e_irq[2]));
  edgecap_ref #(.W(W), .KIND(0), .CAP(1'b0), .BITW(1'b1)) m3 (
    .clk(clk), .rst(rst), .pins(pins), .addr(addr), .rd(rd), .wr(wr), .wd(wd),
    .exp_rdata(e_rdata[3]), .exp_irq(e_irq[3]));

  always @(posedge clk) if (rd) last_addr <= addr;

  function automatic string rd_tag(int inst, logic [1:0] a);
    if (a == 2'd0) return "R2";
    if (a == 2'd2) return "R8";
    if (a == 2'd1) return "R11";
    case (inst)
      0:       return "R5";
      1:       return "R6";
      2:       return "R3";
      default: return "R10";
    endcase
  endfunction

  // Compared every cycle; R13 covers the zero between reads, R9 the irq level.
  always @(negedge clk) begin
    if (chk_on && !done) begin
      for (int i = 0; i < 4; i++) begin
        n_chk++;
        if (rdata[i] !== e_rdata[i]) begin
          n_bad++;
          $display("FAIL %s R13 inst%0d readdata actual=%h expected=%h",
                   rd_tag(i, last_addr), i, rdata[i], e_rdata[i]);
        end
        n_chk++;
        if (irqs[i] !== e_irq[i]) begin
          n_bad++;
          $display("FAIL R9 inst%0d irq actual=%b expected=%b", i, irqs[i], e_irq[i]);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [W-1:0] d);
    addr = a; wd = d; wr = 1'b1;
    tick(1);
    wr = 1'b0; wd = '0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    addr = a; rd = 1'b1;
    tick(1);
    rd = 1'b0;
  endtask

  task automatic read_all();
    bus_rd(2'd0); bus_rd(2'd2); bus_rd(2'd3); bus_rd(2'd1); tick(1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R12: everything zero straight after reset
    for (int i = 0; i < 4; i++) begin
      n_chk++;
      if (rdata[i] !== '0 || irqs[i] !== 1'b0) begin
        n_bad++;
        $display("FAIL R12 inst%0d after reset actual=%h/%b expected=00/0",
                 i, rdata[i], irqs[i]);
      end
    end
    chk_on = 1'b1;
    read_all();
    bus_wr(2'd2, 8'hFF);                // R8 enable all
    pins = 8'h01; tick(4); read_all();  // R1 rising bit 0
    pins = 8'h00; tick(4); read_all();  // falling bit 0
    pins = 8'hA5; tick(4); read_all();
    pins = 8'h5A; tick(10); read_all(); // R4 flags held over time
    bus_wr(2'd3, 8'h0F); read_all();    // R5 / R6 clear behaviour
    // R7: pin change, then clear exactly when detection happens
    pins = 8'hFF; tick(2); bus_wr(2'd3, 8'hFF); tick(1); read_all();
    bus_wr(2'd3, 8'hFF); read_all();
    bus_wr(2'd2, 8'h0F); read_all();    // R9 mask gates irq
    pins = 8'h0F; tick(4); read_all();
    pins = 8'hF0; tick(4); read_all();
    // R11: writes to offsets 0 and 1 change nothing
    bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hFF); read_all();
    // one-cycle pulse
    pins = 8'h81; tick(1); pins = 8'hF0; tick(5); read_all();
    bus_wr(2'd2, 8'h00); read_all();
    bus_wr(2'd2, 8'hFF);
    // dense deterministic mix
    for (int k = 0; k < 400; k++) begin
      pins = W'((k * 37) ^ (k >> 2) ^ (k * k));
      addr = 2'(k % 4 == 1 ? (k / 4) : k);
      rd = k[0];
      wr = (k % 7 == 3);
      wd = W'(k * 53);
      tick(1);
    end
    rd = 1'b0; wr = 1'b0;
    tick(5); read_all();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule